// File: doc/BRIEF.md
# Landing-Pad Expectation Tracker

This block follows, for one hart, whether the next retired instruction must be a landing pad. An indirect jump through a general register arms a one-bit expectation flag. A landing-pad instruction, which is an add-upper-immediate-to-pc whose destination is the zero register, then compares its 20-bit label with bits 31:12 of the guard register value (register x7) and either disarms the flag or raises a fault. Jumps through the two link registers (x1, x5) or through the guard register (x7) never arm the flag. A label of zero matches any guard value.

The pipeline reports each retired event on a valid strobe together with the fields already decoded. The block selects the enable for the current privilege from three configuration bits. It also reports a fault when the instruction fetched while the flag is armed is not a landing pad. On trap entry the flag is saved into a per-privilege previous-state bit and cleared. On a trap return it is restored from that bit when the return target has the feature enabled. All outputs are registered.

Top module: `lpad_tracker`

## Requirements
- R1: After reset the armed flag, both saved bits, both fault outputs and the fault code are all 0 (0 = no landing pad expected, 1 = expected).
- R2: A retired indirect jump with the current enable on arms the flag one cycle later, unless its source register index is 1, 5 or 7, in which case the flag is left unchanged.
- R3: The enable for privilege code 3 (machine) is `cfgMachEn`, for code 1 (supervisor) `cfgSupEn`, and for code 0 (user) `cfgUserEn`, or `cfgSupEn` when supervisor mode is not implemented. The reserved code 2 is always disabled.
- R4: A landing pad retired while enabled and armed, with a label of zero or a label equal to guard bits 31:12, clears the flag and raises no fault.
- R5: A landing pad retired while enabled and armed, with a nonzero label that differs from guard bits 31:12, pulses `lpFault` for one cycle and leaves the flag armed.
- R6: A landing pad retired while disabled or not armed changes no state and raises no fault.
- R7: A fetch reported while the flag is armed and not marked as a landing pad pulses `fetchViol` for one cycle. A fetch of a landing pad raises nothing.
- R8: `faultCode` is 2 in any cycle in which `lpFault` or `fetchViol` is 1, and 0 otherwise.
- R9: Trap entry into machine mode copies the flag into `mSavedElp`, and trap entry into supervisor mode copies it into `sSavedElp`. In both cases the flag is cleared.
- R10: A machine return (or supervisor return) loads the flag from `mSavedElp` (or `sSavedElp`) when the enable of the target privilege `retPriv` is on, and clears it otherwise. The saved bit that was used becomes 0.
- R11: Trap entry overrides every other state change in the same cycle, and a fault detected in that cycle is still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| privMode | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| cfgMachEn | input | 1 | Feature enable for machine mode |
| cfgSupEn | input | 1 | Feature enable for supervisor mode |
| cfgUserEn | input | 1 | Feature enable for user mode |
| jrValid | input | 1 | Indirect jump retired |
| jrSrcReg | input | 5 | Source register index of that jump |
| lpadValid | input | 1 | Landing-pad instruction retired |
| lpadLabel | input | 20 | Label carried by the landing pad |
| guardReg | input | XLEN | Current value of the guard register x7 |
| fetchValid | input | 1 | Instruction fetched and about to execute |
| fetchIsLpad | input | 1 | That fetched instruction is a landing pad |
| trapValid | input | 1 | Trap taken this cycle |
| trapToMach | input | 1 | 1 when the trap goes to machine mode, 0 for supervisor |
| mretValid | input | 1 | Machine trap return retired |
| sretValid | input | 1 | Supervisor trap return retired |
| retPriv | input | 2 | Privilege the return goes to |
| elpState | output | 1 | Landing pad expected flag |
| mSavedElp | output | 1 | Flag saved by machine trap entry |
| sSavedElp | output | 1 | Flag saved by supervisor trap entry |
| lpFault | output | 1 | Label mismatch fault pulse |
| fetchViol | output | 1 | Non-landing-pad fetch while armed |
| faultCode | output | 4 | Cause code while a fault is reported |

## Verification
Every result of this block sits in a register, so each event appears on the outputs exactly one rising edge after the cycle in which its strobe was driven. The bench changes the inputs on a falling edge and reads the outputs on the following falling edge. The value read therefore belongs to the vector just applied, and the next vector is driven at that same falling edge. Same-cycle collisions, such as a mismatching landing pad together with a trap, are applied as one combined cycle and checked one edge later in the same way.

// File: rtl/lpad_pkg.sv
package lpad_pkg;
  localparam logic ELP_NONE = 1'b0;
  localparam logic ELP_EXP  = 1'b1;

  typedef enum logic [1:0] {
    PRIV_U    = 2'b00,
    PRIV_S    = 2'b01,
    PRIV_RSVD = 2'b10,
    PRIV_M    = 2'b11
  } priv_e;

  // strobes from control to datapath, one cycle's worth
  typedef struct packed {
    logic trapM;
    logic trapS;
    logic retM;
    logic retS;
    logic restoreOk;
    logic clearElp;
    logic setElp;
    logic raiseFault;
    logic raiseFetch;
  } strobe_t;
endpackage

// File: rtl/lpad_en_sel.sv
module lpad_en_sel #(
  parameter bit HAS_SMODE = 1'b1
) (
  input  logic [1:0] priv,
  input  logic       cfgMach,
  input  logic       cfgSup,
  input  logic       cfgUser,
  output logic       en
);
  import lpad_pkg::*;
  logic userEn;

  generate
    if (HAS_SMODE) begin : g_userOwn
      assign userEn = cfgUser;
    end else begin : g_userFromMach
      assign userEn = cfgSup;
    end
  endgenerate

  always_comb begin
    unique case (priv_e'(priv))
      PRIV_M:  en = cfgMach;
      PRIV_S:  en = cfgSup;
      PRIV_U:  en = userEn;
      default: en = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpad_ctrl.sv
module lpad_ctrl #(
  parameter int LBL_W = 20
) (
  input  logic             elpState,
  input  logic             curEn,
  input  logic             retEn,
  input  logic             jrValid,
  input  logic [4:0]       jrSrcReg,
  input  logic             lpadValid,
  input  logic [LBL_W-1:0] lpadLabel,
  input  logic [LBL_W-1:0] guardLbl,
  input  logic             fetchValid,
  input  logic             fetchIsLpad,
  input  logic             trapValid,
  input  logic             trapToMach,
  input  logic             mretValid,
  input  logic             sretValid,
  output lpad_pkg::strobe_t st
);
  localparam logic [4:0] LINK_A = 5'd1;
  localparam logic [4:0] LINK_B = 5'd5;
  localparam logic [4:0] GUARD  = 5'd7;

  logic srcExempt, lpadArmed, labelOk;

  always_comb begin
    srcExempt = (jrSrcReg == LINK_A) || (jrSrcReg == LINK_B) || (jrSrcReg == GUARD);
    lpadArmed = lpadValid && curEn && (elpState == lpad_pkg::ELP_EXP);
    labelOk   = (lpadLabel == '0) || (lpadLabel == guardLbl);

    st.trapM      = trapValid && trapToMach;
    st.trapS      = trapValid && !trapToMach;
    st.retM       = !trapValid && mretValid;
    st.retS       = !trapValid && !mretValid && sretValid;
    st.restoreOk  = retEn;
    st.clearElp   = lpadArmed && labelOk;
    st.setElp     = jrValid && curEn && !srcExempt;
    st.raiseFault = lpadArmed && !labelOk;
    st.raiseFetch = fetchValid && !fetchIsLpad && (elpState == lpad_pkg::ELP_EXP);
  end
endmodule

// File: rtl/lpad_state.sv
module lpad_state #(
  parameter int          CODE_W    = 4,
  parameter logic [3:0]  FAULT_CODE = 4'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  lpad_pkg::strobe_t st,
  output logic              elpState,
  output logic              mSavedElp,
  output logic              sSavedElp,
  output logic              lpFault,
  output logic              fetchViol,
  output logic [CODE_W-1:0] faultCode
);
  import lpad_pkg::*;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      elpState  <= ELP_NONE;
      mSavedElp <= ELP_NONE;
      sSavedElp <= ELP_NONE;
    end else if (st.trapM) begin
      mSavedElp <= elpState;
      elpState  <= ELP_NONE;
    end else if (st.trapS) begin
      sSavedElp <= elpState;
      elpState  <= ELP_NONE;
    end else if (st.retM) begin
      elpState  <= st.restoreOk ? mSavedElp : ELP_NONE;
      mSavedElp <= ELP_NONE;
    end else if (st.retS) begin
      elpState  <= st.restoreOk ? sSavedElp : ELP_NONE;
      sSavedElp <= ELP_NONE;
    end else if (st.clearElp) begin
      elpState  <= ELP_NONE;
    end else if (st.setElp) begin
      elpState  <= ELP_EXP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lpFault   <= 1'b0;
      fetchViol <= 1'b0;
      faultCode <= '0;
    end else begin
      lpFault   <= st.raiseFault;
      fetchViol <= st.raiseFetch;
      faultCode <= (st.raiseFault || st.raiseFetch) ? CODE_W'(FAULT_CODE) : '0;
    end
  end

  // R9: trap entry always leaves the flag cleared
  p_trap_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (st.trapM || st.trapS) |=> (elpState == ELP_NONE));
  // R9: machine trap entry captures the prior flag
  p_trapm_saves_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.trapM |=> (mSavedElp == $past(elpState)));
  // R10: a return consumes its saved bit
  p_ret_drops_saved_r10: assert property (@(posedge clk) disable iff (!rstN)
    st.retM |=> (mSavedElp == ELP_NONE));
  // R5: a label fault without a trap keeps the flag armed
  p_fault_keeps_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st.raiseFault && !st.trapM && !st.trapS) |=> (elpState == ELP_EXP));
  // R8: a code is shown exactly while some fault is reported
  p_code_pairs_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lpFault || fetchViol) |-> (faultCode != '0));
endmodule

// File: rtl/lpad_tracker.sv
module lpad_tracker #(
  parameter int         XLEN       = 64,
  parameter int         LBL_W      = 20,
  parameter int         LBL_LO     = 12,
  parameter int         CODE_W     = 4,
  parameter logic [3:0] FAULT_CODE = 4'd2,
  parameter bit         HAS_SMODE  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        privMode,
  input  logic              cfgMachEn,
  input  logic              cfgSupEn,
  input  logic              cfgUserEn,
  input  logic              jrValid,
  input  logic [4:0]        jrSrcReg,
  input  logic              lpadValid,
  input  logic [LBL_W-1:0]  lpadLabel,
  input  logic [XLEN-1:0]   guardReg,
  input  logic              fetchValid,
  input  logic              fetchIsLpad,
  input  logic              trapValid,
  input  logic              trapToMach,
  input  logic              mretValid,
  input  logic              sretValid,
  input  logic [1:0]        retPriv,
  output logic              elpState,
  output logic              mSavedElp,
  output logic              sSavedElp,
  output logic              lpFault,
  output logic              fetchViol,
  output logic [CODE_W-1:0] faultCode
);
  localparam int LBL_HI = LBL_LO + LBL_W - 1;

  logic curEn, retEn;
  logic [LBL_W-1:0] guardLbl;
  lpad_pkg::strobe_t st;

  assign guardLbl = guardReg[LBL_HI:LBL_LO];

  lpad_en_sel #(.HAS_SMODE(HAS_SMODE)) uCurEn (
    .priv(privMode), .cfgMach(cfgMachEn), .cfgSup(cfgSupEn),
    .cfgUser(cfgUserEn), .en(curEn));

  lpad_en_sel #(.HAS_SMODE(HAS_SMODE)) uRetEn (
    .priv(retPriv), .cfgMach(cfgMachEn), .cfgSup(cfgSupEn),
    .cfgUser(cfgUserEn), .en(retEn));

  lpad_ctrl #(.LBL_W(LBL_W)) uCtrl (
    .elpState(elpState), .curEn(curEn), .retEn(retEn),
    .jrValid(jrValid), .jrSrcReg(jrSrcReg),
    .lpadValid(lpadValid), .lpadLabel(lpadLabel), .guardLbl(guardLbl),
    .fetchValid(fetchValid), .fetchIsLpad(fetchIsLpad),
    .trapValid(trapValid), .trapToMach(trapToMach),
    .mretValid(mretValid), .sretValid(sretValid), .st(st));

  lpad_state #(.CODE_W(CODE_W), .FAULT_CODE(FAULT_CODE)) uState (
    .clk(clk), .rstN(rstN), .st(st),
    .elpState(elpState), .mSavedElp(mSavedElp), .sSavedElp(sSavedElp),
    .lpFault(lpFault), .fetchViol(fetchViol), .faultCode(faultCode));

  // R2: jumps through link or guard registers never arm an idle flag
  p_exempt_jump_r2: assert property (@(posedge clk) disable iff (!rstN)
    (jrValid && (jrSrcReg == 5'd1 || jrSrcReg == 5'd5 || jrSrcReg == 5'd7)
     && !elpState && !mretValid && !sretValid && !trapValid) |=> !elpState);
endmodule

// File: tb/tb_lpad_tracker.sv
module tb_lpad_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;

  localparam logic [3:0] OP_NONE = 4'd0, OP_JR = 4'd1, OP_LPAD = 4'd2,
    OP_FETCH = 4'd3, OP_FETCHLP = 4'd4, OP_TRAPM = 4'd5, OP_TRAPS = 4'd6,
    OP_MRET = 4'd7, OP_SRET = 4'd8;

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  priv;
    logic [2:0]  cfg;   // {mach, sup, user}
    logic [4:0]  rs1;
    logic [19:0] lbl;
    logic [19:0] glbl;
    logic [1:0]  ret;
    logic [4:0]  exp;   // {elp, mSaved, sSaved, lpFault, fetchViol}
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{OP_JR,      2'd3, 3'b111, 5'd6,  20'd0, 20'd0, 2'd0, 5'b10000}, // R2 arm
    '{OP_LPAD,    2'd3, 3'b111, 5'd0,  20'd5, 20'd5, 2'd0, 5'b00000}, // R4 match
    '{OP_JR,      2'd3, 3'b111, 5'd1,  20'd0, 20'd0, 2'd0, 5'b00000}, // R2 x1
    '{OP_JR,      2'd3, 3'b111, 5'd5,  20'd0, 20'd0, 2'd0, 5'b00000}, // R2 x5
    '{OP_JR,      2'd3, 3'b111, 5'd7,  20'd0, 20'd0, 2'd0, 5'b00000}, // R2 x7
    '{OP_JR,      2'd3, 3'b111, 5'd10, 20'd0, 20'd0, 2'd0, 5'b10000}, // R2
    '{OP_LPAD,    2'd3, 3'b111, 5'd0,  20'd3, 20'd5, 2'd0, 5'b10010}, // R5
    '{OP_LPAD,    2'd3, 3'b111, 5'd0,  20'd0, 20'd5, 2'd0, 5'b00000}, // R4 wildcard
    '{OP_LPAD,    2'd3, 3'b111, 5'd0,  20'd9, 20'd5, 2'd0, 5'b00000}, // R6 idle
    '{OP_JR,      2'd3, 3'b111, 5'd12, 20'd0, 20'd0, 2'd0, 5'b10000},
    '{OP_FETCH,   2'd3, 3'b111, 5'd0,  20'd0, 20'd0, 2'd0, 5'b10001}, // R7
    '{OP_FETCHLP, 2'd3, 3'b111, 5'd0,  20'd0, 20'd0, 2'd0, 5'b10000}, // R7
    '{OP_TRAPM,   2'd3, 3'b111, 5'd0,  20'd0, 20'd0, 2'd0, 5'b01000}, // R9
    '{OP_MRET,    2'd3, 3'b111, 5'd0,  20'd0, 20'd0, 2'd3, 5'b10000}, // R10
    '{OP_TRAPS,   2'd3, 3'b111, 5'd0,  20'd0, 20'd0, 2'd0, 5'b00100}, // R9
    '{OP_SRET,    2'd1, 3'b110, 5'd0,  20'd0, 20'd0, 2'd0, 5'b00000}, // R10 off
    '{OP_JR,      2'd3, 3'b111, 5'd6,  20'd0, 20'd0, 2'd0, 5'b10000},
    '{OP_TRAPS,   2'd3, 3'b111, 5'd0,  20'd0, 20'd0, 2'd0, 5'b00100},
    '{OP_SRET,    2'd1, 3'b111, 5'd0,  20'd0, 20'd0, 2'd1, 5'b10000}, // R10 on
    '{OP_LPAD,    2'd1, 3'b111, 5'd0,  20'd0, 20'd1, 2'd0, 5'b00000},
    '{OP_JR,      2'd1, 3'b101, 5'd6,  20'd0, 20'd0, 2'd0, 5'b00000}, // R3 sup off
    '{OP_JR,      2'd0, 3'b001, 5'd6,  20'd0, 20'd0, 2'd0, 5'b10000}, // R3 user on
    '{OP_LPAD,    2'd0, 3'b001, 5'd0,  20'd7, 20'd7, 2'd0, 5'b00000},
    '{OP_JR,      2'd3, 3'b011, 5'd6,  20'd0, 20'd0, 2'd0, 5'b00000}, // R3 mach off
    '{OP_JR,      2'd2, 3'b111, 5'd6,  20'd0, 20'd0, 2'd0, 5'b00000}, // R3 reserved
    '{OP_JR,      2'd3, 3'b111, 5'd6,  20'd0, 20'd0, 2'd0, 5'b10000},
    '{OP_LPAD,    2'd3, 3'b011, 5'd0,  20'd3, 20'd5, 2'd0, 5'b10000}, // R6 disabled
    '{OP_MRET,    2'd3, 3'b111, 5'd0,  20'd0, 20'd0, 2'd3, 5'b00000}  // R10 restores 0
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] privMode, retPriv;
  logic cfgMachEn, cfgSupEn, cfgUserEn;
  logic jrValid, lpadValid, fetchValid, fetchIsLpad;
  logic trapValid, trapToMach, mretValid, sretValid;
  logic [4:0] jrSrcReg;
  logic [19:0] lpadLabel;
  logic [XLEN-1:0] guardReg;
  logic elpState, mSavedElp, sSavedElp, lpFault, fetchViol;
  logic [3:0] faultCode;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpad_tracker dut (
    .clk(clk), .rstN(rstN), .privMode(privMode),
    .cfgMachEn(cfgMachEn), .cfgSupEn(cfgSupEn), .cfgUserEn(cfgUserEn),
    .jrValid(jrValid), .jrSrcReg(jrSrcReg),
    .lpadValid(lpadValid), .lpadLabel(lpadLabel), .guardReg(guardReg),
    .fetchValid(fetchValid), .fetchIsLpad(fetchIsLpad),
    .trapValid(trapValid), .trapToMach(trapToMach),
    .mretValid(mretValid), .sretValid(sretValid), .retPriv(retPriv),
    .elpState(elpState), .mSavedElp(mSavedElp), .sSavedElp(sSavedElp),
    .lpFault(lpFault), .fetchViol(fetchViol), .faultCode(faultCode));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    jrValid = 0; jrSrcReg = 0; lpadValid = 0; lpadLabel = 0;
    fetchValid = 0; fetchIsLpad = 0; trapValid = 0; trapToMach = 0;
    mretValid = 0; sretValid = 0; retPriv = 0; guardReg = '0;
  endtask

  task automatic drive(input vec_t v);
    idle();
    privMode = v.priv;
    {cfgMachEn, cfgSupEn, cfgUserEn} = v.cfg;
    jrSrcReg = v.rs1; lpadLabel = v.lbl; retPriv = v.ret;
    guardReg = {32'h0, v.glbl, 12'h5A5};
    case (v.op)
      OP_JR:      jrValid = 1;
      OP_LPAD:    lpadValid = 1;
      OP_FETCH:   fetchValid = 1;
      OP_FETCHLP: begin fetchValid = 1; fetchIsLpad = 1; end
      OP_TRAPM:   begin trapValid = 1; trapToMach = 1; end
      OP_TRAPS:   trapValid = 1;
      OP_MRET:    mretValid = 1;
      OP_SRET:    sretValid = 1;
      default:    ;
    endcase
  endtask

  function automatic string stateTag(input logic [3:0] op);
    case (op)
      OP_JR:              return "R2 state";
      OP_LPAD:            return "R4 state";
      OP_FETCH, OP_FETCHLP: return "R7 state";
      OP_TRAPM, OP_TRAPS: return "R9 state";
      default:            return "R10 state";
    endcase
  endfunction

  task automatic checkOuts(input int idx, input logic [4:0] e);
    string pre;
    pre = $sformatf("v%0d ", idx);
    check({pre, stateTag(VECS[idx].op), " elp"}, 8'(elpState), 8'(e[4]));
    check({pre, "R9 mSaved"}, 8'(mSavedElp), 8'(e[3]));
    check({pre, "R9 sSaved"}, 8'(sSavedElp), 8'(e[2]));
    check({pre, "R5 lpFault"}, 8'(lpFault), 8'(e[1]));
    check({pre, "R7 fetchViol"}, 8'(fetchViol), 8'(e[0]));
    check({pre, "R8 faultCode"}, 8'(faultCode), (e[1] | e[0]) ? 8'd2 : 8'd0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    idle();
    privMode = 2'd3; cfgMachEn = 1; cfgSupEn = 1; cfgUserEn = 1;
    rstN = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset elp", 8'(elpState), 8'd0);
    check("R1 reset saved", 8'({mSavedElp, sSavedElp}), 8'd0);
    check("R1 reset faults", 8'({lpFault, fetchViol, faultCode}), 8'd0);
    rstN = 1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      checkOuts(i, VECS[i].exp);
    end

    // R11: mismatching landing pad together with machine trap entry
    drive(VECS[0]);                 // arm
    @(negedge clk);
    check("R11 setup elp", 8'(elpState), 8'd1);
    idle();
    privMode = 2'd3; {cfgMachEn, cfgSupEn, cfgUserEn} = 3'b111;
    lpadValid = 1; lpadLabel = 20'd3; guardReg = {32'h0, 20'd5, 12'h0};
    trapValid = 1; trapToMach = 1;
    @(negedge clk);
    check("R11 trap wins elp", 8'(elpState), 8'd0);
    check("R11 saved prior", 8'(mSavedElp), 8'd1);
    check("R11 fault still reported", 8'(lpFault), 8'd1);
    check("R11 code", 8'(faultCode), 8'd2);

    // R3: supervisor enable alone arms in supervisor mode
    idle();
    privMode = 2'd1; {cfgMachEn, cfgSupEn, cfgUserEn} = 3'b010;
    jrValid = 1; jrSrcReg = 5'd9;
    @(negedge clk);
    check("R3 sup enable arms", 8'(elpState), 8'd1);
    check("R10 mSaved untouched", 8'(mSavedElp), 8'd1);

    // R6: disabled landing pad mismatch leaves flag and raises nothing
    idle();
    privMode = 2'd1; {cfgMachEn, cfgSupEn, cfgUserEn} = 3'b101;
    lpadValid = 1; lpadLabel = 20'hABCDE; guardReg = '0;
    @(negedge clk);
    check("R6 flag kept", 8'(elpState), 8'd1);
    check("R6 no fault", 8'({lpFault, faultCode}), 8'd0);

    // R1: reset mid-run returns everything to zero
    idle();
    rstN = 0;
    @(negedge clk);
    check("R1 rerun reset elp", 8'(elpState), 8'd0);
    check("R1 rerun reset saved", 8'({mSavedElp, sSavedElp}), 8'd0);
    rstN = 1;
    @(negedge clk);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule